// File: doc/BRIEF.md
# Triplexed LCD Drive Sequencer

This block produces the drive timing for a liquid-crystal panel multiplexed three ways: three common (backplane) electrodes, each crossed by every segment electrode, so that one segment electrode carries three display segments. From the system clock it derives a frame of six equal phases. In every phase it emits a 2-bit level code for each backplane and for each segment electrode. An external resistor ladder turns each code into one of four voltages: the supply, the one-third tap, the two-thirds tap, or the display reference.

The first three phases each make one backplane active with the backplane high against the segments. The last three phases repeat the same order with the polarity reversed, so every segment sees no net DC voltage over a frame. The display contents come in as a plain bit vector: one on/off bit per segment, held by whatever logic owns the display image. A shutdown input stops the frame timing and pulls every output to the supply code. No data stream crosses the block's edge, so every pin is a plain level and there is no handshake.

The phase length in clocks is a parameter. Its default gives a 90 Hz frame from a 200 MHz clock.

Top module: `lcd_triplex_seq`

## Requirements
- R1: While reset is asserted every backplane and segment output carries the supply code, and after reset the frame starts at the first phase, with backplane 1 active and not inverted.
- R2: The level codes are supply = 2'b00, one-third tap = 2'b01, two-thirds tap = 2'b10, display reference = 2'b11. Each phase lasts CLKS_PER_PHASE clocks. Phases run in the fixed order 0 to 5 and then wrap to 0. Phase p activates backplane (p mod 3)+1, and phases 3 to 5 are the inverted half.
- R3: The active backplane (bp_lvl bits [2k+1:2k] for backplane k+1) carries the supply code in the normal half and the display reference code in the inverted half.
- R4: The two inactive backplanes carry the two-thirds tap code in the normal half and the one-third tap code in the inverted half.
- R5: In the normal half, segment line l (seg_lvl bits [2l+1:2l]) carries the display reference code when seg_on bit 3l+k is set for the active backplane k+1, and the one-third tap code when that bit is clear.
- R6: In the inverted half, the segment line carries the supply code when the active segment is on, and the two-thirds tap code when it is off.
- R7: A clock edge that samples shutdown high drives every output to the supply code and returns the frame to phase 0 with the phase count cleared. After shutdown falls, the frame restarts from phase 0.
- R8: Over any complete frame with steady segment inputs, the sum of the backplane-to-segment voltage across every segment is zero, counting the codes as 3, 2, 1 and 0 ladder steps.
- R9: Outputs are registered: a change on seg_on or shutdown shows on the outputs after exactly one clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shutdown | input | 1 | Stops the frame and forces all outputs to the supply code |
| seg_on | input | 3*NUM_LINES | Segment on bits; bit 3l+k is the segment of line l on backplane k+1 |
| bp_lvl | output | 6 | Level codes of the three backplanes, 2 bits each |
| seg_lvl | output | 2*NUM_LINES | Level codes of the segment lines, 2 bits each |

## Verification
Every output is one register stage away from its cause. A level produced by the phase counter, by seg_on or by shutdown at one rising edge is therefore on the pins until the next rising edge. The bench's reference model steps with each rising edge and computes the codes the design must show after that edge. The bench then compares every backplane and segment code at the following falling edge, so each comparison lands in the middle of the cycle the result belongs to. Phase length is measured as a run of falling-edge samples. DC balance is summed from those same samples over frames that start at a phase-0 boundary and contain no input change or shutdown.

// File: rtl/lcd3_pkg.sv
package lcd3_pkg;
  localparam int NUM_BP     = 3;
  localparam int NUM_PHASES = 2 * NUM_BP;
  localparam int PHASE_W    = $clog2(NUM_PHASES);
  localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(NUM_PHASES - 1);
  localparam logic [PHASE_W-1:0] HALF_PHASE = PHASE_W'(NUM_BP);

  typedef enum logic [1:0] {
    LVL_VDD   = 2'b00,
    LVL_VH    = 2'b01,
    LVL_VL    = 2'b10,
    LVL_VDISP = 2'b11
  } lvl_e;

  // Backplane level for a given activity and half of the frame
  function automatic logic [1:0] bp_level(input logic active, input logic inverted);
    if (active) return inverted ? LVL_VDISP : LVL_VDD;
    else        return inverted ? LVL_VH    : LVL_VL;
  endfunction

  // Segment line level for the segment on the active backplane
  function automatic logic [1:0] seg_level(input logic on, input logic inverted);
    if (inverted) return on ? LVL_VDD   : LVL_VL;
    else          return on ? LVL_VDISP : LVL_VH;
  endfunction
endpackage

// File: rtl/lcd3_phase_timer.sv
module lcd3_phase_timer
  import lcd3_pkg::*;
#(
  parameter int CLKS_PER_PHASE = 370370
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shutdown,
  output logic [PHASE_W-1:0] phase_q
);
  localparam int DIV_W = (CLKS_PER_PHASE > 1) ? $clog2(CLKS_PER_PHASE) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLKS_PER_PHASE - 1);

  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      phase_q <= '0;
    end else if (shutdown) begin
      div_q   <= '0;
      phase_q <= '0;
    end else if (div_q == DIV_LAST) begin
      div_q   <= '0;
      phase_q <= (phase_q == LAST_PHASE) ? '0 : phase_q + 1'b1;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  AST_PHASE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= LAST_PHASE); // R2

  AST_PHASE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!shutdown && div_q == DIV_LAST) |=>
      phase_q == (($past(phase_q) == LAST_PHASE) ? '0 : $past(phase_q) + 1'b1)); // R2

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!shutdown && div_q != DIV_LAST) |=> $stable(phase_q)); // R2

  AST_SHUT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> (phase_q == '0 && div_q == '0)); // R7
endmodule

// File: rtl/lcd3_bp_drv.sv
module lcd3_bp_drv
  import lcd3_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  shutdown,
  input  logic [PHASE_W-1:0]    phase,
  output logic [2*NUM_BP-1:0]   bp_lvl
);
  logic                inverted;
  logic [NUM_BP-1:0]   active;
  logic [2*NUM_BP-1:0] bp_nxt;
  logic [NUM_BP-1:0]   extreme;

  assign inverted = (phase >= HALF_PHASE);

  for (genvar k = 0; k < NUM_BP; k++) begin : g_bp
    assign active[k] = (phase == PHASE_W'(k)) || (phase == PHASE_W'(k + NUM_BP));
    assign bp_nxt[2*k +: 2] = shutdown ? LVL_VDD : bp_level(active[k], inverted);
    assign extreme[k] = (bp_lvl[2*k +: 2] == LVL_VDD) || (bp_lvl[2*k +: 2] == LVL_VDISP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bp_lvl <= {NUM_BP{LVL_VDD}};
    else        bp_lvl <= bp_nxt;
  end

  AST_ONE_ACTIVE_BP: assert property (@(posedge clk) disable iff (!rst_n)
    !shutdown |=> $countones(extreme) == 1); // R3

  AST_BP_SHUTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> bp_lvl == {NUM_BP{LVL_VDD}}); // R7
endmodule

// File: rtl/lcd3_seg_drv.sv
module lcd3_seg_drv
  import lcd3_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shutdown,
  input  logic [PHASE_W-1:0] phase,
  input  logic [NUM_BP-1:0]  seg_on,
  output logic [1:0]         lvl
);
  logic       inverted;
  logic [1:0] bp_idx;

  assign inverted = (phase >= HALF_PHASE);
  assign bp_idx   = inverted ? 2'(phase - HALF_PHASE) : 2'(phase);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lvl <= LVL_VDD;
    else if (shutdown) lvl <= LVL_VDD;
    else               lvl <= seg_level(seg_on[bp_idx], inverted);
  end

  AST_SEG_NORMAL_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (!shutdown && !inverted) |=> (lvl == LVL_VDISP || lvl == LVL_VH)); // R5

  AST_SEG_INVERTED_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (!shutdown && inverted) |=> (lvl == LVL_VDD || lvl == LVL_VL)); // R6

  AST_SEG_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (!shutdown && seg_on == '1) |=> (lvl == LVL_VDISP || lvl == LVL_VDD)); // R9
endmodule

// File: rtl/lcd_triplex_seq.sv
module lcd_triplex_seq
  import lcd3_pkg::*;
#(
  parameter int NUM_LINES      = 30,
  parameter int CLKS_PER_PHASE = 370370
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      shutdown,
  input  logic [NUM_BP*NUM_LINES-1:0] seg_on,
  output logic [2*NUM_BP-1:0]       bp_lvl,
  output logic [2*NUM_LINES-1:0]    seg_lvl
);
  logic [PHASE_W-1:0] phase;

  lcd3_phase_timer #(.CLKS_PER_PHASE(CLKS_PER_PHASE)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .shutdown (shutdown),
    .phase_q  (phase)
  );

  lcd3_bp_drv u_bp (
    .clk      (clk),
    .rst_n    (rst_n),
    .shutdown (shutdown),
    .phase    (phase),
    .bp_lvl   (bp_lvl)
  );

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    lcd3_seg_drv u_seg (
      .clk      (clk),
      .rst_n    (rst_n),
      .shutdown (shutdown),
      .phase    (phase),
      .seg_on   (seg_on[NUM_BP*l +: NUM_BP]),
      .lvl      (seg_lvl[2*l +: 2])
    );
  end

  AST_RESET_VDD: assert property (@(posedge clk)
    !rst_n |-> (bp_lvl == '0 && seg_lvl == '0)); // R1
endmodule

// File: tb/lcd_triplex_seq_test.sv
`timescale 1ns/1ps
module lcd_triplex_seq_test;
  localparam int L = 4;
  localparam int C = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shutdown = 1'b0;
  logic [3*L-1:0] seg_on = '0;
  logic [5:0] bp_lvl;
  logic [2*L-1:0] seg_lvl;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  bit dirty = 0;

  lcd_triplex_seq #(.NUM_LINES(L), .CLKS_PER_PHASE(C)) uut (
    .clk(clk), .rst_n(rst_n), .shutdown(shutdown),
    .seg_on(seg_on), .bp_lvl(bp_lvl), .seg_lvl(seg_lvl)
  );

  always #2.5 clk = ~clk;

  // Reference model: codes VDD=0, VH=1, VL=2, VDISP=3
  int m_div = 0, m_phase = 0, o_phase = -1, prev_o = -1;
  int e_bp[3] = '{0, 0, 0};
  int t_bp[3] = '{1, 1, 1};
  int e_seg[L];
  int t_seg[L];
  int sums[3][L];
  bit frame_ok = 0;

  initial for (int l = 0; l < L; l++) begin e_seg[l] = 0; t_seg[l] = 1; end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_div = 0; m_phase = 0; o_phase = -1;
      for (int k = 0; k < 3; k++) begin e_bp[k] = 0; t_bp[k] = 1; end
      for (int l = 0; l < L; l++) begin e_seg[l] = 0; t_seg[l] = 1; end
    end else begin
      bit inv;
      int act;
      inv = (m_phase >= 3);
      act = m_phase % 3;
      o_phase = shutdown ? -1 : m_phase;
      for (int k = 0; k < 3; k++) begin
        if (shutdown)      begin e_bp[k] = 0; t_bp[k] = 7; end      // R7
        else if (k == act) begin e_bp[k] = inv ? 3 : 0; t_bp[k] = 3; end // R3
        else               begin e_bp[k] = inv ? 1 : 2; t_bp[k] = 4; end // R4
      end
      for (int l = 0; l < L; l++) begin
        bit on;
        on = seg_on[3*l + act];
        if (shutdown) begin e_seg[l] = 0; t_seg[l] = 7; end
        else if (!inv) begin e_seg[l] = on ? 3 : 1; t_seg[l] = 5; end  // R5
        else           begin e_seg[l] = on ? 0 : 2; t_seg[l] = 6; end  // R6
      end
      if (shutdown) begin m_div = 0; m_phase = 0; end
      else if (m_div == C - 1) begin m_div = 0; m_phase = (m_phase + 1) % 6; end
      else m_div++;
    end
  end

  // Per-clock comparison and DC bookkeeping (R8)
  always @(negedge clk) begin
    if (!done) begin
      bit bad;
      bad = 0;
      compared++;
      for (int k = 0; k < 3; k++)
        if (int'(bp_lvl[2*k +: 2]) != e_bp[k]) begin
          bad = 1;
          $display("FAIL R%0d bp%0d actual=%0d expected=%0d", t_bp[k], k, bp_lvl[2*k +: 2], e_bp[k]);
        end
      for (int l = 0; l < L; l++)
        if (int'(seg_lvl[2*l +: 2]) != e_seg[l]) begin
          bad = 1;
          $display("FAIL R%0d seg%0d actual=%0d expected=%0d", t_seg[l], l, seg_lvl[2*l +: 2], e_seg[l]);
        end
      if (bad) mismatched++;

      if (o_phase == 0 && prev_o != 0) begin
        if (frame_ok) begin
          bit dc_bad;
          dc_bad = 0;
          compared++;
          for (int k = 0; k < 3; k++)
            for (int l = 0; l < L; l++)
              if (sums[k][l] != 0) begin
                dc_bad = 1;
                $display("FAIL R8 dc bp%0d seg%0d actual=%0d expected=0", k, l, sums[k][l]);
              end
          if (dc_bad) mismatched++;
        end
        for (int k = 0; k < 3; k++) for (int l = 0; l < L; l++) sums[k][l] = 0;
        frame_ok = 1;
      end
      if (dirty || o_phase < 0) begin frame_ok = 0; dirty = 0; end
      for (int k = 0; k < 3; k++)
        for (int l = 0; l < L; l++)
          sums[k][l] += int'(seg_lvl[2*l +: 2]) - int'(bp_lvl[2*k +: 2]);
      prev_o = o_phase;
    end
  end

  task automatic set_pattern(input logic [3*L-1:0] p);
    seg_on = p;
    dirty = 1;
  endtask

  // R2: backplane 1 stays at the supply code for exactly C samples
  task automatic check_phase_len();
    int run;
    run = 0;
    @(negedge clk);
    while (bp_lvl[1:0] == 2'b00) @(negedge clk);
    while (bp_lvl[1:0] != 2'b00) @(negedge clk);
    while (bp_lvl[1:0] == 2'b00) begin run++; @(negedge clk); end
    compared++;
    if (run != C) begin
      mismatched++;
      $display("FAIL R2 phase length actual=%0d expected=%0d", run, C);
    end
  endtask

  initial begin
    logic [3*L-1:0] lfsr;
    repeat (4) @(negedge clk);
    compared++; // R1 reset state
    if (bp_lvl !== '0 || seg_lvl !== '0) begin
      mismatched++;
      $display("FAIL R1 reset bp=%h seg=%h expected=0/0", bp_lvl, seg_lvl);
    end
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    set_pattern('1);
    check_phase_len();
    repeat (40) @(negedge clk);
    set_pattern(12'b101101001110);
    repeat (40) @(negedge clk);
    lfsr = 12'hACE;
    for (int i = 0; i < 6; i++) begin
      lfsr = {lfsr[10:0], lfsr[11] ^ lfsr[10] ^ lfsr[9] ^ lfsr[3]};
      set_pattern(lfsr);
      repeat (40) @(negedge clk);
    end
    repeat (2) @(negedge clk);
    set_pattern({seg_on[3*L-1:3], 3'b111});
    @(negedge clk);
    compared++; // R9 one-edge latency
    if (seg_lvl[1:0] != 2'b11 && seg_lvl[1:0] != 2'b00) begin
      mismatched++;
      $display("FAIL R9 seg0 actual=%0d expected=3 or 0", seg_lvl[1:0]);
    end
    repeat (5) @(negedge clk);
    shutdown = 1'b1;
    @(negedge clk);
    compared++; // R7 shutdown
    if (bp_lvl !== '0 || seg_lvl !== '0) begin
      mismatched++;
      $display("FAIL R7 shutdown bp=%h seg=%h expected=0/0", bp_lvl, seg_lvl);
    end
    repeat (10) @(negedge clk);
    shutdown = 1'b0;
    repeat (60) @(negedge clk);
    set_pattern(12'h5A3);
    repeat (60) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL R2 watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule